// File: doc/BRIEF.md
# Dual-Channel Register-Mapped PWM Controller

This block is a small memory-mapped pulse-width modulator with two independent output channels. Software programs each channel through a simple write/read register port: one shared control word carries an 8-bit field per channel, and each channel owns a period register and a duty register. Both values are counted in cycles of the block's clock, which serves as the base PWM clock.

A channel runs only when its field has both the run bit and the PWM-mode bit set. While running, its counter steps from 0 to period−1 and wraps. The output is active while the count is below the duty value, and the polarity bit can invert it. New period and duty values are held back until the counter wraps, so a reprogrammed channel never emits a cut-short or stretched pulse. Clearing a channel's field parks it: the counter is held at zero and the pin sits at the idle level set by its polarity bit.

Register map (byte offsets): 0x00 is the control word, with channel n in bits [8n+7:8n]. In each field, bit 0 is run, bit 4 is invert and bit 7 is PWM mode. Channel n's period register is at 0x10 + 0x10·n and its duty register is at 0x14 + 0x10·n.

Top module: `twin_pwm_unit`

## Requirements
- R1: After a synchronous active-low reset, both outputs are 0 and every mapped register reads 0.
- R2: A write to offset 0x00 stores wdata[15:0] as the control word, and bits 31:16 read 0. A write to 0x10/0x14/0x20/0x24 stores wdata[15:0], and its upper bits read 0. A write to any other offset changes nothing, and reads of other offsets return 0.
- R3: With run (bit 0) and mode (bit 7) set and polarity (bit 4) clear, a channel's output is high for exactly `duty` cycles of every `period`-cycle interval.
- R4: A duty value greater than or equal to the period gives a constantly high output. A duty of 0 gives a constantly low output (normal polarity).
- R5: With bit 4 set, the running output is the inverse of the normal waveform, and a stopped channel idles high instead of low.
- R6: If either run (bit 0) or mode (bit 7) is clear, the channel is stopped: its output holds the idle level and its counter is held at 0.
- R7: Period or duty writes made while a channel runs take effect only at the next counter wrap. The pulse in progress keeps its old length.
- R8: Channel 1 uses control bits 15:8 and registers 0x20/0x24, independently of channel 0. Stopping one channel leaves the other's waveform unchanged.
- R9: After the field is cleared and the channel is started again, the first pulse starts at count 0 and is exactly `duty` cycles long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base PWM clock and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 2 | Channel outputs, bit n is channel n |

## Verification
A corrupted counter or shadow register shows up at a pin within one period: the high count inside any window that is a whole number of periods moves away from `duty` per period. If a shadow copy updates at the wrong time, the pulse that is in flight when duty is rewritten has the wrong length, so pulse widths are measured right around such a write. A run-enable decode fault shows at once as a pin that toggles while the channel should sit at its idle level, or that stays idle while it should run.

// File: rtl/twin_pwm_pkg.sv
// Shared constants for the dual-channel PWM controller: register offsets
// and bit positions inside one channel's 8-bit control field.
package twin_pwm_pkg;
    localparam int FIELD_W      = 8;
    localparam int F_RUN_BIT    = 0;
    localparam int F_INV_BIT    = 4;
    localparam int F_MODE_BIT   = 7;
    localparam int CTRL_OFS     = 'h00;
    localparam int CH_STRIDE    = 'h10;
    localparam int PER_OFS      = 'h10;
    localparam int DUTY_OFS     = 'h14;

    // Byte offset of channel n's period register.
    function automatic int period_ofs(input int n);
        return PER_OFS + CH_STRIDE * n;
    endfunction

    // Byte offset of channel n's duty register.
    function automatic int duty_ofs(input int n);
        return DUTY_OFS + CH_STRIDE * n;
    endfunction
endpackage

// File: rtl/tp_regfile.sv
// Register store for the PWM controller: the shared control word plus one
// period and one duty register per channel. Writes are taken on the clock
// edge. Reads are combinational from the address.
// Assumes NUM_CH*8 <= DATA_W and CNT_W <= DATA_W.
module tp_regfile
    import twin_pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_CH*FIELD_W-1:0] ctrl,
    output logic [CNT_W-1:0]          period [NUM_CH],
    output logic [CNT_W-1:0]          duty   [NUM_CH]
);
    localparam int CTRL_W = NUM_CH * FIELD_W;

    // Control word write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr && int'(addr) == CTRL_OFS)
            ctrl <= wdata[CTRL_W-1:0];
    end

    // Per-channel period and duty registers.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chreg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                period[n] <= '0;
                duty[n]   <= '0;
            end else if (wr) begin
                if (int'(addr) == period_ofs(n)) period[n] <= wdata[CNT_W-1:0];
                if (int'(addr) == duty_ofs(n))   duty[n]   <= wdata[CNT_W-1:0];
            end
        end
    end

    // Read multiplexer: unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (int'(addr) == CTRL_OFS) rdata[CTRL_W-1:0] = ctrl;
        for (int n = 0; n < NUM_CH; n++) begin
            if (int'(addr) == period_ofs(n)) rdata[CNT_W-1:0] = period[n];
            if (int'(addr) == duty_ofs(n))   rdata[CNT_W-1:0] = duty[n];
        end
    end

    // R2: a control write lands in the control word one edge later.
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && int'(addr) == CTRL_OFS) |=> ctrl == $past(wdata[CTRL_W-1:0]));
endmodule

// File: rtl/tp_channel.sv
// One PWM channel: a free-running counter that wraps at the active period,
// shadow copies of period and duty reloaded only at a wrap (or while
// stopped), and a registered output stage with polarity inversion.
// Assumes the field, period and duty inputs are synchronous to clk.
module tp_channel
    import twin_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field,
    input  logic [CNT_W-1:0]   period_in,
    input  logic [CNT_W-1:0]   duty_in,
    output logic               wave
);
    logic             running;
    logic             invert;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] sh_period;
    logic [CNT_W-1:0] sh_duty;
    logic [CNT_W:0]   cnt_plus;
    logic             wrap;

    assign running  = field[F_RUN_BIT] && field[F_MODE_BIT];
    assign invert   = field[F_INV_BIT];
    assign cnt_plus = {1'b0, cnt} + 1'b1;
    assign wrap     = cnt_plus >= {1'b0, sh_period};

    // Counter: held at zero while stopped, wraps after period-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !running || wrap)
            cnt <= '0;
        else
            cnt <= cnt_plus[CNT_W-1:0];
    end

    // Shadow copies: follow the registers while stopped, else reload at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_period <= '0;
            sh_duty   <= '0;
        end else if (!running || wrap) begin
            sh_period <= period_in;
            sh_duty   <= duty_in;
        end
    end

    // Output stage: compare against duty, apply polarity, idle when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave <= 1'b0;
        else if (running)
            wave <= (cnt < sh_duty) ^ invert;
        else
            wave <= invert;
    end

    // R6: a stopped channel leaves its counter at zero.
    a_r6_stopped_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> cnt == '0);

    // R3: a running counter stays below a nonzero period.
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (running && sh_period != '0) |-> cnt < sh_period);

    // R7: shadow values stay fixed between wraps.
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(sh_period) && $stable(sh_duty)));

    // R5: a stopped channel drives the idle level chosen by polarity.
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> wave == $past(invert));
endmodule

// File: rtl/twin_pwm_unit.sv
// Top of the dual-channel PWM controller: a register store and one
// counter/output channel per control field. The clock is the base PWM
// clock. Reset is synchronous, active low.
module twin_pwm_unit
    import twin_pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CTRL_W = NUM_CH * FIELD_W;

    logic [CTRL_W-1:0] ctrl;
    logic [CNT_W-1:0]  period [NUM_CH];
    logic [CNT_W-1:0]  duty   [NUM_CH];

    tp_regfile #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl),
        .period(period), .duty(duty)
    );

    // One channel per control field.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        tp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .field(ctrl[n*FIELD_W +: FIELD_W]),
            .period_in(period[n]), .duty_in(duty[n]),
            .wave(pwm_out[n])
        );
    end

    // R1: outputs are low in the first cycle after reset.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> pwm_out == '0);
endmodule

// File: tb/sim_twin_pwm_unit.sv
`timescale 1ns/1ps
module sim_twin_pwm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit busy = 1'b0;

    typedef struct {
        int    kind;   // 0: high count over window, 1: next pulse length
        int    ch;
        int    n;
        int    exp;
        string req;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    twin_pwm_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_addr = a[7:0]; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string req);
        reg_addr = a[7:0];
        #1;
        check(req, int'(reg_rdata), exp);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input int kind, input int ch, input int n,
                        input int exp, input string req);
        item_t it;
        it.kind = kind; it.ch = ch; it.n = n; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0 && !busy);
        @(negedge clk);
    endtask

    task automatic window(input int ch, input int n, input int exp, input string req);
        push(0, ch, n, exp, req);
        drain();
    endtask

    // Monitor: pops expected items and measures the outputs at negedges.
    initial begin
        forever begin
            item_t it;
            int cnt;
            wait (q.size() != 0);
            it = q.pop_front();
            busy = 1'b1;
            cnt = 0;
            if (it.kind == 0) begin
                for (int i = 0; i < it.n; i++) begin
                    @(negedge clk);
                    cnt += int'(pwm_out[it.ch]);
                end
            end else begin
                while (!pwm_out[it.ch]) @(negedge clk);
                while (pwm_out[it.ch]) begin
                    cnt++;
                    @(negedge clk);
                end
            end
            check(it.req, cnt, it.exp);
            busy = 1'b0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        bit prev;
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs", int'(pwm_out), 0);
        rd_check('h00, 0, "R1 ctrl");
        rd_check('h10, 0, "R1 per0");
        rd_check('h24, 0, "R1 duty1");
        // R2 register map
        wr('h10, 'h1234);
        rd_check('h10, 'h1234, "R2 per0 readback");
        wr('h14, 'hABCD0005);
        rd_check('h14, 'h5, "R2 duty0 truncation");
        wr('h08, 'hFFFF);
        rd_check('h08, 0, "R2 unmapped read");
        rd_check('h10, 'h1234, "R2 unmapped write ignored");
        wr('h00, 'h12349190);
        rd_check('h00, 'h9190, "R2 ctrl width");
        wr('h00, 0);
        // R3 main waveform
        wr('h10, 10); wr('h14, 3); wr('h00, 'h81);
        idle(20);
        window(0, 50, 15, "R3 per10 duty3");
        wr('h10, 7); wr('h14, 5);
        idle(30);
        window(0, 70, 50, "R3 per7 duty5");
        // R4 saturation
        wr('h14, 12); idle(20);
        window(0, 40, 40, "R4 duty>=period");
        wr('h14, 0); idle(20);
        window(0, 40, 0, "R4 duty zero");
        // R5 polarity
        wr('h10, 10); wr('h14, 3); wr('h00, 'h91);
        idle(30);
        window(0, 50, 35, "R5 inverted running");
        wr('h00, 'h10); idle(5);
        window(0, 20, 20, "R5 inverted idle");
        // R6 run requires both bits
        wr('h00, 'h01); idle(5);
        window(0, 30, 0, "R6 run without mode");
        wr('h00, 'h80); idle(5);
        window(0, 30, 0, "R6 mode without run");
        // R9 restart after clear
        wr('h00, 0); wr('h14, 4); idle(5);
        push(1, 0, 0, 4, "R9 first pulse after restart");
        wr('h00, 'h81);
        drain();
        idle(20);
        window(0, 50, 20, "R9 steady after restart");
        // R7 deferred update
        wr('h14, 3); idle(30);
        prev = pwm_out[0];
        forever begin
            @(negedge clk);
            if (pwm_out[0] && !prev) break;
            prev = pwm_out[0];
        end
        push(1, 0, 0, 3, "R7 pulse in flight keeps old duty");
        push(1, 0, 0, 7, "R7 next pulse uses new duty");
        wr('h14, 7);
        drain();
        // R8 second channel
        wr('h20, 8); wr('h24, 2); wr('h00, 'h8181);
        idle(30);
        window(1, 40, 10, "R8 ch1 per8 duty2");
        window(0, 50, 35, "R8 ch0 alongside ch1");
        wr('h00, 'h0081); idle(5);
        window(1, 30, 0, "R8 ch1 stopped");
        window(0, 50, 35, "R8 ch0 unaffected");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule